// File: doc/BRIEF.md
# Lock and Signal Alarm Controller

This block turns two raw health indications from a clock-and-data-recovery receiver into the alarm pins and output gating that the rest of the chip sees. One input is a magnitude of the recovered clock's frequency error, expressed in ppm of nominal. The other is an asynchronous loss-of-signal flag from the analog front end. A squelch request pin and a handful of configuration bits held in a register bank complete the inputs.

Lock is judged with hysteresis. Loss of lock is declared when the error goes above 1000 ppm. It is withdrawn only once the error is below 250 ppm. A latched copy of loss of lock records any drop out of lock. It keeps that record until software pulses a clear bit high and then low. The lock pin can show either the live state or the latched one. The signal-loss pin has a selectable polarity. The squelch request disables the recovered outputs, either both of them or only the data, depending on a mode bit. A status byte carries the three alarm states for readback.

Top module: `lol_alarm_ctrl`

## Requirements
- R1: While reset is held and right after it, the live lock alarm reads 1 (acquiring), the latched alarm reads 0, the signal alarm is inactive, and both output enables are 1.
- R2: An error strictly above 1000 ppm sets the live lock alarm at the next clock edge. An error of exactly 1000 ppm does not set it.
- R3: An error strictly below 250 ppm clears the live lock alarm at the next clock edge. An error from 250 to 1000 ppm inclusive leaves it unchanged.
- R4: With `cfg_lol_sticky`=0 the `lol_pin` shows the live alarm. With `cfg_lol_sticky`=1 it shows the latched alarm.
- R5: The latched alarm becomes 1 in the same edge in which the live alarm goes from 0 to 1. It then stays 1 whatever the error does.
- R6: The latched alarm clears one edge after `clr_sticky` falls from 1 to 0. Holding `clr_sticky` at 1 does not clear it. A new loss in the same edge as the clear wins, and the alarm stays 1.
- R7: `los_async` reaches the alarm through two flops, so a change shows up after the second clock edge. `los_pin` equals that synchronized value when `cfg_los_inv`=0 and its inverse when `cfg_los_inv`=1.
- R8: The squelch pin is synchronized through two flops. When it is high and `cfg_sq_mode`=0, both `clk_en` and `data_en` are 0. When it is high and `cfg_sq_mode`=1, only `data_en` is 0 and `clk_en` stays 1.
- R9: `status` bit 5 holds the synchronized signal-loss state, unaffected by polarity. Bit 4 holds the latched lock alarm and bit 3 the live lock alarm. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| ferr_ppm | input | PPM_W | Frequency error magnitude in ppm of nominal |
| los_async | input | 1 | Asynchronous signal-loss flag, active high |
| squelch_pin | input | 1 | Asynchronous squelch request, active high |
| cfg_lol_sticky | input | 1 | Lock pin source: 0 live, 1 latched |
| cfg_los_inv | input | 1 | Signal-loss pin polarity: 0 active high, 1 active low |
| cfg_sq_mode | input | 1 | Squelch mode: 0 gate clock and data, 1 gate data only |
| clr_sticky | input | 1 | Latched-alarm clear bit, acts on its 1-to-0 transition |
| lol_pin | output | 1 | Loss-of-lock pin |
| los_pin | output | 1 | Loss-of-signal pin |
| clk_en | output | 1 | Recovered clock output enable |
| data_en | output | 1 | Recovered data output enable |
| status | output | 8 | Alarm status byte |

## Verification
The bench puts the error exactly on 250 and 1000 ppm and one count either side of each. A comparison with the wrong strictness, or thresholds swapped, flips the live alarm at one of these points. It holds the clear bit high across several edges and then drops it. A design that clears on the level would lose the latched alarm too early, and one that misses the edge would never clear it. It also makes a new loss coincide with the falling clear, and it checks the two-edge latency and the polarity of the signal-loss path. A design that gates the clock in data-only squelch mode would show a dropped `clk_en`.

// File: rtl/lol_alarm_pkg.sv
package lol_alarm_pkg;
  localparam int unsigned STAT_W       = 8;
  localparam int unsigned STAT_LIVE_B  = 3;
  localparam int unsigned STAT_STICK_B = 4;
  localparam int unsigned STAT_LOS_B   = 5;

  function automatic logic err_above(input int unsigned err, input int unsigned thr);
    return err > thr;
  endfunction

  function automatic logic err_below(input int unsigned err, input int unsigned thr);
    return err < thr;
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(input logic los, input logic stick,
                                                    input logic live);
    logic [STAT_W-1:0] s;
    s = '0;
    s[STAT_LOS_B]   = los;
    s[STAT_STICK_B] = stick;
    s[STAT_LIVE_B]  = live;
    return s;
  endfunction
endpackage

// File: rtl/lol_bit_sync.sv
module lol_bit_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/lol_hyst_det.sv
module lol_hyst_det
  import lol_alarm_pkg::*;
#(
  parameter int PPM_W   = 12,
  parameter int SET_PPM = 1000,
  parameter int CLR_PPM = 250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PPM_W-1:0] ferr,
  output logic             lol_live,
  output logic             lose_evt
);
  logic too_far, close_in;

  assign too_far  = err_above(32'(ferr), SET_PPM);
  assign close_in = err_below(32'(ferr), CLR_PPM);
  assign lose_evt = too_far && !lol_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lol_live <= 1'b1;
    else if (too_far)  lol_live <= 1'b1;
    else if (close_in) lol_live <= 1'b0;
  end
endmodule

// File: rtl/lol_sticky.sv
module lol_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_bit,
  output logic sticky,
  output logic clr_evt
);
  logic clr_d;

  assign clr_evt = clr_d && !clr_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_d  <= 1'b0;
      sticky <= 1'b0;
    end else begin
      clr_d <= clr_bit;
      if (set_evt)      sticky <= 1'b1;
      else if (clr_evt) sticky <= 1'b0;
    end
  end
endmodule

// File: rtl/lol_alarm_ctrl.sv
module lol_alarm_ctrl
  import lol_alarm_pkg::*;
#(
  parameter int PPM_W       = 12,
  parameter int SET_PPM     = 1000,
  parameter int CLR_PPM     = 250,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PPM_W-1:0] ferr_ppm,
  input  logic             los_async,
  input  logic             squelch_pin,
  input  logic             cfg_lol_sticky,
  input  logic             cfg_los_inv,
  input  logic             cfg_sq_mode,
  input  logic             clr_sticky,
  output logic             lol_pin,
  output logic             los_pin,
  output logic             clk_en,
  output logic             data_en,
  output logic [STAT_W-1:0] status
);
  localparam int NSYNC = 2;

  logic [NSYNC-1:0] async_in, sync_out;
  logic los_s, sq_s;
  logic lol_live, lose_evt, sticky, clr_evt;

  assign async_in = {squelch_pin, los_async};
  assign los_s    = sync_out[0];
  assign sq_s     = sync_out[1];

  lol_bit_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(async_in), .q(sync_out)
  );

  lol_hyst_det #(.PPM_W(PPM_W), .SET_PPM(SET_PPM), .CLR_PPM(CLR_PPM)) u_hyst (
    .clk(clk), .rst_n(rst_n), .ferr(ferr_ppm), .lol_live(lol_live), .lose_evt(lose_evt)
  );

  lol_sticky u_stick (
    .clk(clk), .rst_n(rst_n), .set_evt(lose_evt), .clr_bit(clr_sticky),
    .sticky(sticky), .clr_evt(clr_evt)
  );

  assign lol_pin = cfg_lol_sticky ? sticky : lol_live;
  assign los_pin = los_s ^ cfg_los_inv;
  assign data_en = !sq_s;
  assign clk_en  = !(sq_s && !cfg_sq_mode);
  assign status  = pack_status(los_s, sticky, lol_live);
endmodule

module lol_alarm_chk #(
  parameter int PPM_W   = 12,
  parameter int SET_PPM = 1000,
  parameter int CLR_PPM = 250
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PPM_W-1:0] ferr,
  input logic             lol_live,
  input logic             sticky,
  input logic             clr_evt,
  input logic             lose_evt,
  input logic             clk_en,
  input logic             data_en
);
  logic in_band;
  assign in_band = (32'(ferr) >= CLR_PPM) && (32'(ferr) <= SET_PPM);

  AST_LOL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(ferr) > SET_PPM) |=> lol_live);                                  // R2
  AST_LOL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(ferr) < CLR_PPM) |=> !lol_live);                                 // R3
  AST_LOL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    in_band |=> $stable(lol_live));                                       // R3
  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    lose_evt |=> sticky);                                                 // R5
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky && !clr_evt) |=> sticky);                                     // R6
  AST_SQ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> !data_en);                                                // R8
endmodule

bind lol_alarm_ctrl lol_alarm_chk #(.PPM_W(PPM_W), .SET_PPM(SET_PPM), .CLR_PPM(CLR_PPM)) u_chk (
  .clk(clk), .rst_n(rst_n), .ferr(ferr_ppm), .lol_live(lol_live), .sticky(sticky),
  .clr_evt(clr_evt), .lose_evt(lose_evt), .clk_en(clk_en), .data_en(data_en)
);

// File: tb/lol_alarm_ctrl_bench.sv
`timescale 1ns/1ps
module lol_alarm_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] ferr_ppm = '0;
  logic los_async = 1'b0, squelch_pin = 1'b0;
  logic cfg_lol_sticky = 1'b0, cfg_los_inv = 1'b0, cfg_sq_mode = 1'b0, clr_sticky = 1'b0;
  logic lol_pin, los_pin, clk_en, data_en;
  logic [7:0] status;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lol_alarm_ctrl u_lol_alarm_ctrl (
    .clk(clk), .rst_n(rst_n), .ferr_ppm(ferr_ppm), .los_async(los_async),
    .squelch_pin(squelch_pin), .cfg_lol_sticky(cfg_lol_sticky), .cfg_los_inv(cfg_los_inv),
    .cfg_sq_mode(cfg_sq_mode), .clr_sticky(clr_sticky), .lol_pin(lol_pin),
    .los_pin(los_pin), .clk_en(clk_en), .data_en(data_en), .status(status)
  );

  // bench reference state
  bit m_lol = 1, m_stk = 0, m_clrd = 0, m_los1 = 0, m_los = 0, m_sq1 = 0, m_sq = 0;

  logic [11:0] exp_q [$];
  string       tag_q [$];

  function automatic logic [11:0] obs();
    return {lol_pin, los_pin, clk_en, data_en, status};
  endfunction

  function automatic logic [11:0] predict();
    logic [7:0] st;
    st = 8'h00;
    if (m_los) st = st | 8'h20;
    if (m_stk) st = st | 8'h10;
    if (m_lol) st = st | 8'h08;
    return {(cfg_lol_sticky ? m_stk : m_lol), (m_los != cfg_los_inv),
            !(m_sq && (cfg_sq_mode == 1'b0)), !m_sq, st};
  endfunction

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
    end
  endtask

  // driver: one clock edge, model advanced, expected value queued
  task automatic cyc(string tag);
    bit loss, fall;
    @(posedge clk);
    loss = (ferr_ppm >= 12'd1001) && !m_lol;
    fall = m_clrd && !clr_sticky;
    if (ferr_ppm >= 12'd1001) m_lol = 1;
    else if (ferr_ppm <= 12'd249) m_lol = 0;
    if (loss) m_stk = 1;
    else if (fall) m_stk = 0;
    m_clrd = clr_sticky;
    m_los = m_los1; m_los1 = los_async;
    m_sq = m_sq1;   m_sq1 = squelch_pin;
    #1;
    exp_q.push_back(predict());
    tag_q.push_back(tag);
    @(negedge clk);
    #1;
  endtask

  // monitor
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      check(tag_q.pop_front(), obs(), exp_q.pop_front());
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset values", obs(), 12'b1_0_1_1_0000_1000);
    #1 rst_n = 1'b1;
    ferr_ppm = 12'd500; cyc("R1 acquiring after reset"); cyc("R3 band hold");
    ferr_ppm = 12'd250; cyc("R3 at 250 holds");
    ferr_ppm = 12'd249; cyc("R3 below 250 clears");
    ferr_ppm = 12'd1000; cyc("R2 at 1000 no set");
    ferr_ppm = 12'd600; cyc("R3 band hold locked");
    ferr_ppm = 12'd1001; cyc("R2 above 1000 sets, R5 latch");
    ferr_ppm = 12'd100; cyc("R5 latch holds"); cyc("R5 latch holds again");
    cfg_lol_sticky = 1'b1; #1; cyc("R4 pin shows latched");
    check("R4 pin equals latched", {11'd0, lol_pin}, 12'd1);
    clr_sticky = 1'b1; cyc("R6 level no clear"); cyc("R6 level no clear 2");
    clr_sticky = 1'b0; cyc("R6 falling clears");
    check("R6 latched cleared on pin", {11'd0, lol_pin}, 12'd0);
    cfg_lol_sticky = 1'b0; #1; cyc("R4 pin shows live");
    clr_sticky = 1'b1; cyc("R6 arm");
    clr_sticky = 1'b0; ferr_ppm = 12'd2000; cyc("R6 set wins over clear");
    cfg_lol_sticky = 1'b1; ferr_ppm = 12'd10; cyc("R6 latched kept");
    cfg_lol_sticky = 1'b0;
    los_async = 1'b1; cyc("R7 first edge"); cyc("R7 second edge, R9 bit5");
    cfg_los_inv = 1'b1; #1; cyc("R7 inverted polarity");
    los_async = 1'b0; cyc("R7 clear 1"); cyc("R7 clear 2");
    cfg_los_inv = 1'b0;
    squelch_pin = 1'b1; cyc("R8 sync 1"); cyc("R8 mode0 both gated");
    cfg_sq_mode = 1'b1; #1; cyc("R8 mode1 data only");
    check("R8 clock kept in mode1", {10'd0, clk_en, data_en}, 12'b10);
    squelch_pin = 1'b0; cyc("R8 release 1"); cyc("R8 release 2");
    ferr_ppm = 12'd1500; cyc("R9 status live+latched");
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule